// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Controller

This block is the digital control side of a two-channel, 256-step digitally adjustable resistor. A host writes to it over a three-wire serial link: a serial clock, an active-low select and a data line. All three are sampled into the block's system clock domain. Each selected rising edge of the serial clock shifts one bit into a 10-bit register. When the select returns high, the register is decoded. Its upper two bits are an address and its lower eight bits are a wiper code, and the code is written into one of two channel latches.

The register's top bit leaves on a serial output, so several blocks can be chained and fed with one long frame. That output is open-drain, and it is modelled as a pull-low enable. An active-low shutdown input asks both channels to open terminal A and tie the wiper to terminal B. The latches keep their codes during shutdown, and the serial port keeps working.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After reset, both channel codes are 0x80 (midscale), the shutdown flags are 0 and the pull-low enable is 0.
- R2: A bit is shifted in only on a rising serial clock seen while select is low. Serial clock edges while select is high change nothing.
- R3: Frames are sent MSB first as A1, A0, D7..D0. On the rising edge of select, only the last 10 bits shifted in are decoded, and any earlier extra bits are dropped.
- R4: A0 = 0 writes D7..D0 to channel 1 (code bits [7:0]) and A0 = 1 writes to channel 2 (code bits [15:8]). A1 has no effect. Exactly one channel changes per frame.
- R5: A select rise after fewer than 10 clocks decodes the register as it stands. The bits from earlier frames keep their shifted positions.
- R6: The chained-out bit is the bit shifted in ten clocks earlier. The pull-low enable is 1 exactly when that bit is 0, select is low and shutdown is inactive.
- R7: While select is high, the pull-low enable is 0.
- R8: While shutdown is low, both channels raise terminal-A-open and wiper-to-B. The channel codes are unchanged.
- R9: Frames sent during shutdown still update the latches. After shutdown is released, the flags clear and the codes show the latest latch values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| csn_in | input | 1 | Serial select, active low, asynchronous |
| sdi_in | input | 1 | Serial data in, MSB first |
| shdn_n | input | 1 | Shutdown, active low |
| wiper_code | output | 16 | Channel 2 code [15:8], channel 1 code [7:0] |
| term_a_open | output | 2 | Per channel: open terminal A |
| wiper_to_b | output | 2 | Per channel: short the wiper to terminal B |
| sdo_pull_low | output | 1 | Open-drain serial output: 1 pulls the line low |

## Verification
The hardest state to reach is a shift register whose contents come from several earlier frames. This matters for a short frame, for an over-long frame and for the chained output, whose value depends on bits sent up to ten clocks before. The bench keeps a bit-exact model of the register across frames and never clears it. It runs a 256-frame sweep that visits every address, followed by short, long, 20-bit chained and idle-clock frames. In each case the pull-low enable is compared with the model before every clock, and both codes are compared after every select rise.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    localparam int CODE_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int FRAME_W = CODE_W + ADDR_W;
    localparam int NCH     = 2;
    localparam int SEL_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

    // Positions of the three serial pins inside the synchronizer vector
    localparam int PIN_SDI  = 0;
    localparam int PIN_CSN  = 1;
    localparam int PIN_SCLK = 2;
    localparam int PIN_N    = 3;
endpackage

// File: rtl/dwc_sync.sv
module dwc_sync #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stable;
endmodule

// File: rtl/dwc_frame.sv
module dwc_frame
    import dwc_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          csn_s,
    input  logic          sdi_s,
    output logic [FW-1:0] frame,
    output logic          load_stb
);
    typedef struct packed {
        logic          sclk_prev;
        logic          csn_prev;
        logic [FW-1:0] sr;
    } frame_t;

    frame_t st_d, st_q;
    logic   shift_en;

    always_comb begin
        shift_en       = sclk_s && !st_q.sclk_prev && !csn_s;
        load_stb       = csn_s && !st_q.csn_prev;
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;
        if (shift_en) begin
            st_d.sr = {st_q.sr[FW-2:0], sdi_s};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.csn_prev  <= 1'b1;
            st_q.sr        <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame = st_q.sr;
endmodule

// File: rtl/dwc_latch.sv
module dwc_latch
    import dwc_pkg::*;
#(
    parameter int                 CW  = CODE_W,
    parameter int                 NC  = NCH,
    parameter int                 SW  = SEL_W,
    parameter logic [CODE_W-1:0]  MID = MIDSCALE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [SW-1:0]    sel,
    input  logic [CW-1:0]    data,
    output logic [NC*CW-1:0] codes
);
    for (genvar c = 0; c < NC; c++) begin : g_ch
        logic [CW-1:0] code_d, code_q;

        always_comb begin
            code_d = code_q;
            if (load_stb && (sel == SW'(c))) begin
                code_d = data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= CW'(MID);
            end else begin
                code_q <= code_d;
            end
        end

        assign codes[c*CW +: CW] = code_q;
    end
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import dwc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_in,
    input  logic                  csn_in,
    input  logic                  sdi_in,
    input  logic                  shdn_n,
    output logic [NCH*CODE_W-1:0] wiper_code,
    output logic [NCH-1:0]        term_a_open,
    output logic [NCH-1:0]        wiper_to_b,
    output logic                  sdo_pull_low
);
    localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1) << PIN_CSN;

    logic [PIN_N-1:0]   pins_raw, pins_s;
    logic [FRAME_W-1:0] frame;
    logic               load_stb;
    logic               chain_bit;

    assign pins_raw[PIN_SDI]  = sdi_in;
    assign pins_raw[PIN_CSN]  = csn_in;
    assign pins_raw[PIN_SCLK] = sclk_in;

    dwc_sync #(.W(PIN_N), .RST_VAL(PIN_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    dwc_frame #(.FW(FRAME_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[PIN_SCLK]),
        .csn_s    (pins_s[PIN_CSN]),
        .sdi_s    (pins_s[PIN_SDI]),
        .frame    (frame),
        .load_stb (load_stb)
    );

    dwc_latch #(.CW(CODE_W), .NC(NCH), .SW(SEL_W), .MID(MIDSCALE)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .sel      (frame[CODE_W +: SEL_W]),
        .data     (frame[CODE_W-1:0]),
        .codes    (wiper_code)
    );

    assign chain_bit    = frame[FRAME_W-1];
    assign sdo_pull_low = !chain_bit && !pins_s[PIN_CSN] && shdn_n;
    assign term_a_open  = {NCH{!shdn_n}};
    assign wiper_to_b   = {NCH{!shdn_n}};
endmodule

// File: rtl/dwc_chk.sv
module dwc_chk
    import dwc_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  csn_in,
    input logic                  shdn_n,
    input logic [NCH*CODE_W-1:0] wiper_code,
    input logic [NCH-1:0]        term_a_open,
    input logic [NCH-1:0]        wiper_to_b,
    input logic                  sdo_pull_low
);
    // R8
    shdn_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> ((&term_a_open) && (&wiper_to_b)));

    // R9
    run_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_n |-> ((term_a_open == '0) && (wiper_to_b == '0)));

    // R6
    sdo_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> !sdo_pull_low);

    // R7
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn_in, 2) && $past(csn_in, 3)) |-> !sdo_pull_low);

    // R4
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(wiper_code[CODE_W-1:0]) && !$stable(wiper_code[2*CODE_W-1:CODE_W])));

    // R2
    load_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_code) |-> $past(csn_in, 3));
endmodule

bind dual_wiper_ctrl dwc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn_in       (csn_in),
    .shdn_n       (shdn_n),
    .wiper_code   (wiper_code),
    .term_a_open  (term_a_open),
    .wiper_to_b   (wiper_to_b),
    .sdo_pull_low (sdo_pull_low)
);

// File: tb/dual_wiper_ctrl_tb.sv
module dual_wiper_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        csn_in = 1'b1;
    logic        sdi_in = 1'b0;
    logic        shdn_n = 1'b1;
    logic [15:0] wiper_code;
    logic [1:0]  term_a_open;
    logic [1:0]  wiper_to_b;
    logic        sdo_pull_low;

    int nchk = 0;
    int nerr = 0;

    // bench model
    logic [9:0] msr = '0;
    logic [7:0] m1 = 8'h80;
    logic [7:0] m2 = 8'h80;

    always #2 clk = ~clk;

    dual_wiper_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_in      (sclk_in),
        .csn_in       (csn_in),
        .sdi_in       (sdi_in),
        .shdn_n       (shdn_n),
        .wiper_code   (wiper_code),
        .term_a_open  (term_a_open),
        .wiper_to_b   (wiper_to_b),
        .sdo_pull_low (sdo_pull_low)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_codes(input string tag);
        check({tag, " ch1 code"}, int'(wiper_code[7:0]), int'(m1));
        check({tag, " ch2 code"}, int'(wiper_code[15:8]), int'(m2));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sends n bits of v, MSB first, inside one select-low window
    task automatic send(input logic [31:0] v, input int n, input string tag);
        csn_in = 1'b0;
        wait_clk(6);
        check("R2 sdo before clocks", int'(sdo_pull_low), int'(!msr[9] && shdn_n));
        for (int i = n - 1; i >= 0; i--) begin
            sdi_in  = v[i];
            sclk_in = 1'b0;
            wait_clk(4);
            check("R6 chained sdo", int'(sdo_pull_low), int'(!msr[9] && shdn_n));
            sclk_in = 1'b1;
            wait_clk(4);
            msr = {msr[8:0], v[i]};
        end
        sclk_in = 1'b0;
        wait_clk(4);
        csn_in = 1'b1;
        wait_clk(8);
        if (msr[8]) m2 = msr[7:0];
        else        m1 = msr[7:0];
        check_codes(tag);
        check("R7 sdo released", int'(sdo_pull_low), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog (all R): actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R1 reset state
        check_codes("R1 reset");
        check("R1 flags A", int'(term_a_open), 0);
        check("R1 flags B", int'(wiper_to_b), 0);
        check("R1 sdo", int'(sdo_pull_low), 0);

        // R4 sweep over all addresses and many codes
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            d = 8'(i) ^ 8'h5A;
            send({22'd0, 2'(i), d}, 10, "R4 sweep");
        end

        // R3 over-long frame: leading extra bits dropped
        send(32'h3D3C, 14, "R3 long frame");
        send({4'h0, 2'b10, 8'hA5}, 14, "R3 long frame A1 ignored");

        // R5 short frames
        send(32'h2D, 6, "R5 short frame");
        send(32'h1, 3, "R5 short frame");

        // R2 serial clocks while select high are ignored
        sdi_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk_in = 1'b1; wait_clk(4);
            sclk_in = 1'b0; wait_clk(4);
        end
        send(32'h0, 0, "R2 idle clocks");

        // R6 daisy chain: 20 bits under one select window
        send(32'hB_1234, 20, "R6 chain frame");
        send(32'h4_C3F0, 20, "R6 chain frame");

        // R8 shutdown
        send({22'd0, 2'b00, 8'h11}, 10, "R8 pre-shutdown");
        shdn_n = 1'b0;
        wait_clk(3);
        check("R8 term A open", int'(term_a_open), 3);
        check("R8 wiper to B", int'(wiper_to_b), 3);
        check_codes("R8 kept");

        // R9 loads during shutdown
        send({22'd0, 2'b01, 8'hE7}, 10, "R9 shutdown load");
        send({22'd0, 2'b00, 8'h3B}, 10, "R9 shutdown load");
        shdn_n = 1'b1;
        wait_clk(3);
        check("R9 term A released", int'(term_a_open), 0);
        check("R9 wiper released", int'(wiper_to_b), 0);
        check_codes("R9 resumed");

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule